// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a byte-wide nonvolatile memory sitting on a two-wire serial bus with a clock line and an open-drain data line. It oversamples both bus lines with the system clock and recognises start and stop conditions. It answers when the address byte carries its fixed prefix and the value set on three strap pins. It then takes a two-byte word address and either returns bytes from the array or gathers written bytes into a page buffer.

A stop that ends a write starts a timed internal write cycle. During that cycle the buffered bytes are copied into the register array, and the block ignores the bus completely. A master finds out when the cycle is over by repeatedly sending its address until the device acknowledges it. A write-protect input blocks every change to the array. The array holds 2^ADDR_W bytes. The default is kept small, and ADDR_W = 13 gives the full 8K configuration.

Top module: `twoWireEeprom`

## Requirements
- R1: The device acknowledges an address byte only when its upper four bits are 1010 and bits 3..1 equal `strapAddr`. Bit 0 selects the operation: 1 reads and 0 writes. To acknowledge, the device pulls SDA low (`sdaOe` = 1) during the ninth SCL pulse.
- R2: On an address mismatch the device gives no acknowledge. It then ignores all bus traffic until the next start condition.
- R3: In a write, the device acknowledges the high word-address byte, the low word-address byte and every data byte.
- R4: The word address is `{high byte, low byte}`, and only its low ADDR_W bits are kept. Higher bits have no effect.
- R5: After each data byte, only bits 4..0 of the address pointer increment. Bits above 4 stay fixed. Writing past the end of a 32-byte page wraps to the start of the same page, and later bytes overwrite earlier ones.
- R6: A stop that follows at least one complete data byte starts an internal write cycle lasting WRITE_CYCLES clocks. When the cycle ends, every buffered byte is in the array and no other location has changed.
- R7: While the write cycle runs, the device ignores starts, stops and data, and it never drives SDA. An address sent during the cycle is therefore not acknowledged. Once the cycle has ended, an address is acknowledged again.
- R8: While `wpIn` is 1, the device still acknowledges address and data bytes. A stop then commits nothing and does not start a write cycle, so the device answers at once.
- R9: A read returns the byte at the address pointer, MSB first, and then increments the full ADDR_W-bit pointer. The pointer wraps from the last location to 0. A master acknowledge (SDA low on the ninth pulse) continues the read. A master NACK ends it, and the device then leaves SDA released.
- R10: A stop or a start arriving while a byte is partly transferred discards the buffered data. No write cycle follows.
- R11: After reset `sdaOe` is 0. `sdaOe` changes only while SCL is low.
- R12: A write that ends with a stop after the address bytes alone starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| strapAddr | input | 3 | Hardwired device select value |
| wpIn | input | 1 | Write protect; 1 blocks all array changes |
| sdaOe | output | 1 | Pulls SDA low when 1 (open-drain enable) |

## Verification
Each bus line passes through a synchronizer and an edge register before the control register reacts. An acknowledge or read bit therefore appears about four system clocks after the SCL falling edge that calls for it. The bench holds every SCL phase for eight clocks and samples SDA at the end of the high phase, well after that latency.

The write cycle begins about three clocks after the stop's SDA rise and lasts WRITE_CYCLES clocks. The bench places its first acknowledge poll entirely inside that window, expects it to be refused, and expects a later poll to be accepted. Every expected array byte, including those placed by page wrap-around and pointer roll-over, is computed arithmetically from the addresses and data the bench sent.

// File: rtl/twoWireEepromPkg.sv
package twoWireEepromPkg;
  localparam int PAGE_AW = 5;
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEVADDR, ST_ADDRHI, ST_ADDRLO, ST_WDATA, ST_RDATA, ST_BUSY
  } busState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic               shiftIn;
    logic               loadHi;
    logic               loadPtr;
    logic               storeData;
    logic               loadTx;
    logic               shiftTx;
    logic               clearPage;
    logic               commitEn;
    logic [PAGE_AW-1:0] commitLane;
  } dpStrobe_t;
endpackage

// File: rtl/twoWireLineSense.sv
module twoWireLineSense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [SYNC_STAGES:0] sclPipe;
  logic [SYNC_STAGES:0] sdaPipe;
  logic sclS, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sclPrev = sclPipe[SYNC_STAGES];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sdaPrev = sdaPipe[SYNC_STAGES];

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & ~sdaS & sdaPrev;
  assign stopEv  = sclS & sclPrev & sdaS & ~sdaPrev;
endmodule

// File: rtl/twoWireEepromCtrl.sv
module twoWireEepromCtrl
  import twoWireEepromPkg::*;
#(
  parameter int WRITE_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaS,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic [7:0] rxByte,
  input  logic       anyValid,
  input  logic [2:0] strapAddr,
  input  logic       wpIn,
  output dpStrobe_t  stb,
  output logic       ackDrive,
  output logic       txDrive,
  output logic       busy
);
  localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);

  busState_t         state;
  logic [3:0]        bitCnt;
  logic              inAck, rwSel, masterNack;
  logic [BUSY_W-1:0] busyCnt;

  logic active, rxPhase, byteDone, ackEnd, devMatch, busEvent, commitOk, busyDone;

  assign active   = (state != ST_IDLE) && (state != ST_BUSY);
  assign rxPhase  = (state == ST_DEVADDR) || (state == ST_ADDRHI) ||
                    (state == ST_ADDRLO) || (state == ST_WDATA);
  assign byteDone = sclFall && active && !inAck && (bitCnt == 4'd8);
  assign ackEnd   = sclFall && active && inAck;
  assign devMatch = (rxByte[7:4] == DEV_PREFIX) && (rxByte[3:1] == strapAddr);
  assign busEvent = (startEv || stopEv) && (state != ST_BUSY);
  // a stop right after a byte boundary (one SCL pulse seen) closes a write
  assign commitOk = stopEv && (state == ST_WDATA) && !inAck &&
                    (bitCnt <= 4'd1) && anyValid && !wpIn;
  assign busyDone = (state == ST_BUSY) && (busyCnt == BUSY_W'(WRITE_CYCLES - 1));
  assign busy     = (state == ST_BUSY);

  always_comb begin
    stb            = '0;
    stb.shiftIn    = sclRise && rxPhase && !inAck && (bitCnt < 4'd8);
    stb.loadHi     = byteDone && (state == ST_ADDRHI);
    stb.loadPtr    = byteDone && (state == ST_ADDRLO);
    stb.storeData  = byteDone && (state == ST_WDATA);
    stb.loadTx     = ackEnd && (((state == ST_DEVADDR) && rwSel) ||
                                ((state == ST_RDATA) && !masterNack));
    stb.shiftTx    = sclFall && (state == ST_RDATA) && !inAck &&
                     (bitCnt != 4'd0) && (bitCnt < 4'd8);
    stb.clearPage  = (busEvent && !commitOk) || busyDone;
    stb.commitEn   = busy && (busyCnt < BUSY_W'(PAGE_BYTES)) && !wpIn;
    stb.commitLane = busyCnt[PAGE_AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      inAck      <= 1'b0;
      rwSel      <= 1'b0;
      masterNack <= 1'b0;
      ackDrive   <= 1'b0;
      txDrive    <= 1'b0;
      busyCnt    <= '0;
    end else if (busEvent) begin
      bitCnt     <= '0;
      inAck      <= 1'b0;
      masterNack <= 1'b0;
      ackDrive   <= 1'b0;
      txDrive    <= 1'b0;
      busyCnt    <= '0;
      if (startEv)       state <= ST_DEVADDR;
      else if (commitOk) state <= ST_BUSY;
      else               state <= ST_IDLE;
    end else if (state == ST_BUSY) begin
      busyCnt <= busyCnt + 1'b1;
      if (busyDone) state <= ST_IDLE;
    end else if (active) begin
      if (sclRise) begin
        if (!inAck && (bitCnt < 4'd8)) bitCnt <= bitCnt + 4'd1;
        if (inAck && (state == ST_RDATA)) masterNack <= sdaS;
      end
      if (byteDone) begin
        inAck   <= 1'b1;
        txDrive <= 1'b0;
        if (state == ST_DEVADDR) begin
          rwSel <= rxByte[0];
          if (devMatch) ackDrive <= 1'b1;
          else begin
            state <= ST_IDLE;
            inAck <= 1'b0;
          end
        end else if (state != ST_RDATA) begin
          ackDrive <= 1'b1;
        end
      end
      if (ackEnd) begin
        inAck    <= 1'b0;
        ackDrive <= 1'b0;
        bitCnt   <= '0;
        case (state)
          ST_DEVADDR: begin
            state   <= rwSel ? ST_RDATA : ST_ADDRHI;
            txDrive <= rwSel;
          end
          ST_ADDRHI: state <= ST_ADDRLO;
          ST_ADDRLO: state <= ST_WDATA;
          ST_RDATA: begin
            if (masterNack) state <= ST_IDLE;
            else            txDrive <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twoWireEepromDatapath.sv
module twoWireEepromDatapath
  import twoWireEepromPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaS,
  input  dpStrobe_t  stb,
  output logic [7:0] rxByte,
  output logic       txMsb,
  output logic       anyValid
);
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int ROW_W = ADDR_W - PAGE_AW;

  logic [7:0]        rxShift, txShift, hiByte;
  logic [ADDR_W-1:0] ptr;
  logic [ROW_W-1:0]  pageRow;
  logic [PAGE_AW-1:0] pageOff;
  logic [7:0]        mem [MEM_DEPTH];
  logic [7:0]        pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;

  assign pageRow  = ptr[ADDR_W-1:PAGE_AW];
  assign pageOff  = ptr[PAGE_AW-1:0];
  assign rxByte   = rxShift;
  assign txMsb    = txShift[7];
  assign anyValid = |pageValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      hiByte  <= '0;
      ptr     <= '0;
    end else begin
      if (stb.shiftIn)   rxShift <= {rxShift[6:0], sdaS};
      if (stb.loadHi)    hiByte  <= rxShift;
      if (stb.loadPtr)   ptr     <= ADDR_W'({hiByte, rxShift});
      if (stb.storeData) ptr     <= {pageRow, pageOff + 1'b1};
      if (stb.loadTx) begin
        txShift <= mem[ptr];
        ptr     <= ptr + 1'b1;
      end
      if (stb.shiftTx)   txShift <= {txShift[6:0], 1'b0};
    end
  end

  for (genvar lane = 0; lane < PAGE_BYTES; lane++) begin : gLane
    logic       laneHit, validQ;
    logic [7:0] dataQ;
    assign laneHit = stb.storeData && (pageOff == PAGE_AW'(lane));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              validQ <= 1'b0;
      else if (stb.clearPage) validQ <= 1'b0;
      else if (laneHit)       validQ <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (laneHit) dataQ <= rxShift;
    end
    assign pageValid[lane] = validQ;
    assign pageBuf[lane]   = dataQ;
  end

  // one lane per clock during the write cycle
  always_ff @(posedge clk) begin
    if (stb.commitEn && pageValid[stb.commitLane])
      mem[{pageRow, stb.commitLane}] <= pageBuf[stb.commitLane];
  end
endmodule

// File: rtl/twoWireEeprom.sv
module twoWireEeprom
  import twoWireEepromPkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int WRITE_CYCLES = 200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       wpIn,
  output logic       sdaOe
);
  logic       sdaS, sclRise, sclFall, startEv, stopEv;
  logic [7:0] rxByte;
  logic       txMsb, anyValid, ackDrive, txDrive, busy;
  dpStrobe_t  stb;

  twoWireLineSense #(.SYNC_STAGES(SYNC_STAGES)) uSense (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv)
  );

  twoWireEepromCtrl #(.WRITE_CYCLES(WRITE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .rxByte(rxByte), .anyValid(anyValid),
    .strapAddr(strapAddr), .wpIn(wpIn), .stb(stb), .ackDrive(ackDrive),
    .txDrive(txDrive), .busy(busy)
  );

  twoWireEepromDatapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .stb(stb), .rxByte(rxByte),
    .txMsb(txMsb), .anyValid(anyValid)
  );

  assign sdaOe = ackDrive | (txDrive & ~txMsb);
endmodule

// File: rtl/twoWireEepromChk.sv
module twoWireEepromChk #(
  parameter int WRITE_CYCLES = 200
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaOe,
  input logic busy,
  input logic wpIn,
  input logic loadHi,
  input logic loadPtr,
  input logic storeData,
  input logic loadTx,
  input logic shiftTx
);
  int busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else           busyLen <= 0;
  end

  // R11: the data line only moves while the clock line is low
  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R7: no drive at all during the internal write cycle
  assert_busy_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  // R8: a write cycle only starts when protection was off
  assert_busy_unprotected_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(wpIn));

  // R6: write cycle lasts exactly WRITE_CYCLES clocks
  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == WRITE_CYCLES));

  // R5: pointer-changing datapath actions never coincide
  assert_ptr_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadHi, loadPtr, storeData, loadTx, shiftTx}));
endmodule

bind twoWireEeprom twoWireEepromChk #(.WRITE_CYCLES(WRITE_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .busy(busy), .wpIn(wpIn),
  .loadHi(stb.loadHi), .loadPtr(stb.loadPtr), .storeData(stb.storeData),
  .loadTx(stb.loadTx), .shiftTx(stb.shiftTx)
);

// File: tb/tb_twoWireEeprom.sv
`timescale 1ns/1ps
module tb_twoWireEeprom;
  localparam int ADDR_W = 11;
  localparam int MEM = 1 << ADDR_W;
  localparam int WRITE_CYCLES = 200;
  localparam int PH = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, wp = 1'b0;
  logic sdaOe, sdaLine;
  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [7:0] model [MEM];
  logic [7:0] txq [64];

  always #10 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  twoWireEeprom #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .strapAddr(STRAP), .wpIn(wp), .sdaOe(sdaOe)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; w(PH); sclM = 1'b1; w(PH); sdaM = 1'b0; w(PH); sclM = 1'b0; w(2);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; w(PH); sclM = 1'b1; w(PH); sdaM = 1'b1; w(PH);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; w(PH); sclM = 1'b1; w(PH); sclM = 1'b0; w(2);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    sdaM = 1'b1; w(PH); sclM = 1'b1; w(PH);
    ack = ~sdaLine;
    sclM = 1'b0; w(2);
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(PH); sclM = 1'b1; w(PH); b = {b[6:0], sdaLine}; sclM = 1'b0; w(2);
    end
    sdaM = ~giveAck; w(PH); sclM = 1'b1; w(PH); sclM = 1'b0; w(2);
    sdaM = 1'b1;
  endtask

  task automatic setAddr(input logic [15:0] wa);
    logic a;
    startCond();
    sendByte(DEV_W, a);   checkEq("R1 matching address acknowledged", a, 1);
    sendByte(wa[15:8], a); checkEq("R3 high address byte ack", a, 1);
    sendByte(wa[7:0], a);  checkEq("R3 low address byte ack", a, 1);
  endtask

  task automatic writeSeq(input logic [15:0] wa, input int n);
    logic a;
    setAddr(wa);
    for (int i = 0; i < n; i++) begin
      sendByte(txq[i], a); checkEq("R3 data byte ack", a, 1);
    end
    stopCond();
  endtask

  // R5 model: low five bits wrap inside the page
  task automatic modelWrite(input logic [15:0] wa, input int n);
    int base, off;
    base = int'(wa) & (MEM - 1) & ~31;
    for (int i = 0; i < n; i++) begin
      off = (int'(wa) + i) & 31;
      model[base + off] = txq[i];
    end
  endtask

  task automatic pollOnce(output logic ack);
    startCond(); sendByte(DEV_W, ack); stopCond();
  endtask

  task automatic waitReady(output int polls);
    logic a;
    polls = 0;
    do begin pollOnce(a); polls++; end while (!a && polls < 20);
  endtask

  task automatic readSeq(input logic [15:0] wa, input int n, input string req);
    logic a;
    logic [7:0] b;
    setAddr(wa);
    startCond();
    sendByte(DEV_R, a); checkEq("R1 read address acknowledged", a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      checkEq(req, b, model[(int'(wa) + i) & (MEM - 1)]);
    end
    stopCond();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic a;
    int polls;
    w(5);
    rstN = 1'b1;
    w(5);
    checkEq("R11 sdaOe low after reset", sdaOe, 0);

    // R1 / R2: sweep all strap-field values and a wrong prefix
    for (int v = 0; v < 8; v++) begin
      startCond();
      sendByte({4'b1010, 3'(v), 1'b0}, a);
      checkEq(v == int'(STRAP) ? "R1 match acknowledged" : "R2 mismatch not acknowledged",
              a, (v == int'(STRAP)) ? 1 : 0);
      stopCond();
    end
    startCond();
    sendByte({4'b1011, STRAP, 1'b0}, a); checkEq("R1 wrong prefix refused", a, 0);
    sendByte(DEV_W, a); checkEq("R2 ignored until next start", a, 0);
    stopCond();

    // R3 / R6: fill pages 0..3 with an arithmetic pattern
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 32; i++) txq[i] = 8'((p * 32 + i) * 7 + 3);
      writeSeq(16'(p * 32), 32);
      modelWrite(16'(p * 32), 32);
      waitReady(polls);
    end
    // R9: sequential read crossing page boundaries
    readSeq(16'd0, 128, "R9 sequential read across pages");

    // R6 / R7: busy window and acknowledge polling
    txq[0] = 8'hA5;
    writeSeq(16'd40, 1);
    modelWrite(16'd40, 1);
    pollOnce(a);
    checkEq("R7 poll inside write cycle refused", a, 0);
    waitReady(polls);
    checkEq("R7 poll accepted after write cycle", (polls <= 2) ? 1 : 0, 1);
    readSeq(16'd39, 3, "R6 only the written byte changed");

    // R5: 37 bytes from offset 28 of page 3 wrap and overwrite
    for (int i = 0; i < 37; i++) txq[i] = 8'(8'h50 + i);
    writeSeq(16'd124, 37);
    modelWrite(16'd124, 37);
    waitReady(polls);
    readSeq(16'd96, 32, "R5 page wrap result");

    // R4: address bits above ADDR_W ignored
    txq[0] = 8'h3C;
    writeSeq(16'hF940, 1);
    modelWrite(16'h0140, 1);
    waitReady(polls);
    readSeq(16'h0140, 1, "R4 upper address bits ignored");

    // R9: pointer wraps from the last location to zero
    txq[0] = 8'h7E;
    writeSeq(16'h07FF, 1);
    modelWrite(16'h07FF, 1);
    waitReady(polls);
    readSeq(16'h07FF, 2, "R9 read pointer wraps to zero");
    checkEq("R9 SDA released after master NACK and stop", sdaOe, 0);
    pollOnce(a);
    checkEq("R9 device idle after read end", a, 1);

    // R8: write protect
    wp = 1'b1;
    txq[0] = 8'hEE;
    writeSeq(16'd5, 1);
    pollOnce(a);
    checkEq("R8 protected write starts no cycle", a, 1);
    wp = 1'b0;
    readSeq(16'd5, 1, "R8 protected location unchanged");

    // R10: stop in the middle of a byte
    setAddr(16'd10);
    sendByte(8'h99, a); checkEq("R3 data byte ack", a, 1);
    sendBits(8'h12, 4);
    stopCond();
    pollOnce(a);
    checkEq("R10 mid-byte stop starts no cycle", a, 1);
    readSeq(16'd10, 1, "R10 aborted write left data");

    // R10: repeated start in the middle of a byte
    setAddr(16'd11);
    sendByte(8'h77, a); checkEq("R3 data byte ack", a, 1);
    sendBits(8'hF0, 3);
    startCond();
    sendByte(DEV_W, a); checkEq("R10 restart addressed", a, 1);
    stopCond();
    pollOnce(a);
    checkEq("R10 restart abort starts no cycle", a, 1);
    readSeq(16'd11, 1, "R10 restart aborted write");

    // R12: address-only write
    setAddr(16'd20);
    stopCond();
    pollOnce(a);
    checkEq("R12 address-only write no cycle", a, 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule